// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block runs single-byte transfers on an asynchronous 8-bit NAND bus. A request says whether the byte is a command, an address or data, and whether it is written or read. A 32-bit timing word sets how long each phase lasts. Every transfer goes through four phases in order. First the control lines and write data settle during a setup phase. Next the write or read strobe is held low for a programmed pulse width. The strobe then returns high for a hold phase. Last comes an optional ready-sample wait, and the busy line should not be trusted until it ends. A single-cycle completion pulse marks the end of the transfer.

The timing word has one 16-bit half for reads and one for writes. The half matching the direction of the request is captured when the request is accepted. Each half holds four 4-bit fields. Setup, pulse width and hold give n+1 clocks for a field value n. The ready-sample wait gives 2*n clocks, so a value of zero means there is no wait. For reads, the byte on the bus is captured on the clock edge where the read strobe returns high.

Top module: `nand_strobe_timer`

## Requirements
- R1: Field positions. For a read, setup is `timing[3:0]`, hold is `[7:4]`, pulse width is `[11:8]` and ready wait is `[15:12]`. For a write, the same fields sit 16 bits higher: setup `[19:16]`, hold `[23:20]`, width `[27:24]`, ready wait `[31:28]`. The half that does not match the direction has no effect.
- R2: Setup lasts setup+1 clocks after the accepting edge, with the strobe high, before the strobe falls.
- R3: The active strobe stays low for exactly width+1 clocks.
- R4: Hold lasts hold+1 clocks with the strobe high. During this phase the control lines and the write data stay as they were during setup.
- R5: The ready-sample wait lasts 2*n clocks after hold. When n is 0 there is no wait.
- R6: `req_kind` 2'b01 (command) drives `cle` high from setup through hold. 2'b10 (address) drives `ale` high over the same span. 2'b00 and 2'b11 (data) drive neither line.
- R7: A write pulses only `we_n`, and a read pulses only `re_n`. `dq_oe` is high, with `dq_out` equal to the request byte, from setup through hold of a write, and is never high during a read.
- R8: A read returns in `rdata` the value that `dq_in` had on the last clock of the strobe-low phase.
- R9: A request is accepted only when `idle` is high. A request held at any other time has no effect, including one held during the `done` cycle.
- R10: `done` is a one-cycle pulse after the wait (or after hold, if there is no wait). `idle` rises on the next clock.
- R11: After reset, `idle` is high, both strobes are high, and `cle`, `ale`, `dq_oe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 01 command, 10 address, else data |
| req_wdata | input | 8 | Byte to write |
| timing | input | 32 | Timing word, sampled on acceptance |
| dq_in | input | 8 | Bus value read back |
| idle | output | 1 | Ready to accept a request |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_oe | output | 1 | Bus output enable |
| dq_out | output | 8 | Bus drive value |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | Transfer complete, one cycle |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and a waiting request for the next. The bench holds `req_valid` high, with a changed kind and direction, for a whole transfer and through its `done` cycle. It then checks that only the original transfer's strobe and latch line moved. It also checks that the cycle after `done` is idle with all lines quiet, and that only the cycle after that starts a new setup. The read capture falls on the same edge as the strobe release. This is judged by changing `dq_in` on every low cycle, so that only the value from the last low cycle can match.

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
  parameter int DW = 8,
  parameter int FW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_kind,
  input  logic [DW-1:0]   req_wdata,
  input  logic [8*FW-1:0] timing,
  input  logic [DW-1:0]   dq_in,
  output logic            idle,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic            dq_oe,
  output logic [DW-1:0]   dq_out,
  output logic [DW-1:0]   rdata,
  output logic            done
);
  localparam int CW = FW + 1;
  localparam int HW = 4 * FW;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_WAIT, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] wdata_q;
  logic [FW-1:0] hold_q, width_q, rdy_q;

  logic [HW-1:0] half;
  assign half = req_write ? timing[2*HW-1:HW] : timing[HW-1:0];

  wire busy_bus = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  wire cnt_end  = (cnt == '0);

  assign idle   = (st == S_IDLE);
  assign done   = (st == S_FIN);
  assign cle    = busy_bus && (kind_q == 2'b01);
  assign ale    = busy_bus && (kind_q == 2'b10);
  assign we_n   = !((st == S_PULSE) && wr_q);
  assign re_n   = !((st == S_PULSE) && !wr_q);
  assign dq_oe  = busy_bus && wr_q;
  assign dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      kind_q  <= 2'b00;
      wdata_q <= '0;
      hold_q  <= '0;
      width_q <= '0;
      rdy_q   <= '0;
      rdata   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_SETUP;
          cnt     <= CW'(half[FW-1:0]);
          hold_q  <= half[2*FW-1:FW];
          width_q <= half[3*FW-1:2*FW];
          rdy_q   <= half[4*FW-1:3*FW];
          wr_q    <= req_write;
          kind_q  <= req_kind;
          wdata_q <= req_wdata;
        end
        S_SETUP: if (cnt_end) begin
          st  <= S_PULSE;
          cnt <= CW'(width_q);
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (cnt_end) begin
          st  <= S_HOLD;
          cnt <= CW'(hold_q);
          if (!wr_q) rdata <= dq_in;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt_end) begin
          if (rdy_q == '0) st <= S_FIN;
          else begin
            st  <= S_WAIT;
            cnt <= {rdy_q, 1'b0} - 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (cnt_end) st <= S_FIN;
                else cnt <= cnt - 1'b1;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic done
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r6_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
  a_r7_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);
  a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> !$past(idle));
  a_r4_cle_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cle) |-> (we_n && re_n && $past(we_n) && $past(re_n)));
  a_r9_no_idle_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cle || ale || dq_oe) |-> !idle);
endmodule

bind nand_strobe_timer nand_strobe_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .idle(idle), .cle(cle), .ale(ale),
  .we_n(we_n), .re_n(re_n), .dq_oe(dq_oe), .done(done)
);

// File: tb/nand_strobe_timer_tb_top.sv
module nand_strobe_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_wdata = 8'h00, dq_in = 8'h00;
  logic [31:0] timing = 32'h0;
  logic idle, cle, ale, we_n, re_n, dq_oe, done;
  logic [7:0] dq_out, rdata;

  always #4 clk = ~clk;

  nand_strobe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_wdata(req_wdata), .timing(timing), .dq_in(dq_in),
    .idle(idle), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .dq_oe(dq_oe), .dq_out(dq_out), .rdata(rdata), .done(done)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // {write, kind[1:0], byte[7:0], timing[31:0]}
  localparam logic [42:0] VEC [8] = '{
    {1'b1, 2'b01, 8'h70, 32'h0000_0000},
    {1'b0, 2'b00, 8'h10, 32'hFEDC_1321},
    {1'b1, 2'b10, 8'hC3, 32'h3412_AAAA},
    {1'b1, 2'b00, 8'h5A, 32'h0F0F_5555},
    {1'b0, 2'b01, 8'h40, 32'h1111_F0F0},
    {1'b0, 2'b10, 8'h80, 32'h0000_2777},
    {1'b1, 2'b11, 8'hA5, 32'hF999_0000},
    {1'b0, 2'b00, 8'hE0, 32'hFFFF_FFFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic run_access(input logic [42:0] v);
    logic wr;
    logic [1:0] kd;
    logic [7:0] by;
    logic [15:0] hf;
    int s, h, w, r, n, pre, low, act, oe_cnt, oe_bad, seen_cle, seen_ale, other_low;
    wr = v[42]; kd = v[41:40]; by = v[39:32];
    hf = wr ? v[31:16] : v[15:0];
    s = hf[3:0]; h = hf[7:4]; w = hf[11:8]; r = hf[15:12];
    n = 0; pre = 0; low = 0; act = 0; oe_cnt = 0; oe_bad = 0;
    seen_cle = 0; seen_ale = 0; other_low = 0;
    @(negedge clk);
    chk(idle == 1'b1, "R9 idle before request", idle, 1);
    req_valid = 1'b1; req_write = wr; req_kind = kd; req_wdata = by; timing = v[31:0];
    dq_in = 8'h00;
    @(posedge clk);
    while (n < 200) begin
      @(negedge clk);
      n++;
      // stray request during the transfer (R9)
      req_write = ~wr; req_kind = kd ^ 2'b11; req_wdata = ~by; timing = ~v[31:0];
      if (done) begin
        req_valid = 1'b0;
        break;
      end
      if ((wr ? we_n : re_n) == 1'b0) begin
        low++;
        dq_in = by + 8'(low);
      end else if (low == 0) pre++;
      if ((wr ? re_n : we_n) == 1'b0) other_low++;
      if (cle) seen_cle++;
      if (ale) seen_ale++;
      if (cle || ale) act++;
      if (dq_oe) begin
        oe_cnt++;
        if (dq_out != by) oe_bad++;
      end
    end
    chk(pre == s + 1, "R2 setup clocks", pre, s + 1);
    chk(low == w + 1, "R3 strobe low clocks", low, w + 1);
    chk(n == s + w + h + 4 + 2 * r, "R5 R4 clocks to done", n, s + w + h + 4 + 2 * r);
    chk(other_low == 0, "R7 wrong strobe", other_low, 0);
    chk(seen_cle == ((kd == 2'b01) ? s + w + h + 3 : 0), "R6 cle span", seen_cle,
        (kd == 2'b01) ? s + w + h + 3 : 0);
    chk(seen_ale == ((kd == 2'b10) ? s + w + h + 3 : 0), "R6 ale span", seen_ale,
        (kd == 2'b10) ? s + w + h + 3 : 0);
    chk(oe_cnt == (wr ? s + w + h + 3 : 0), "R7 R1 oe span", oe_cnt, wr ? s + w + h + 3 : 0);
    chk(oe_bad == 0, "R4 write data stable", oe_bad, 0);
    if (!wr) chk(rdata == 8'(by + 8'(w + 1)), "R8 read capture", rdata, by + w + 1);
    @(negedge clk);
    chk(done == 1'b0 && idle == 1'b1, "R10 done single cycle", done, 0);
    chk(we_n && re_n && !cle && !ale && !dq_oe, "R9 no restart", {we_n, re_n}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(idle == 1'b1, "R11 reset idle", idle, 1);
    chk(we_n && re_n, "R11 reset strobes", {we_n, re_n}, 3);
    chk(!cle && !ale && !dq_oe && !done, "R11 reset lines", {cle, ale, dq_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1 && !done, "R11 idle after release", idle, 1);

    for (int i = 0; i < 8; i++) run_access(VEC[i]);

    // request held through the done cycle: accepted only once idle (R9, R10)
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_kind = 2'b01; req_wdata = 8'h33;
    timing = 32'h0000_0000;
    @(posedge clk);
    begin
      int k;
      k = 0;
      while (k < 20) begin
        @(negedge clk);
        k++;
        if (done) break;
      end
      chk(k == 4, "R10 min access length", k, 4);
      @(negedge clk);
      chk(idle == 1'b1 && !cle && !done, "R9 not accepted during done", idle, 1);
      @(negedge clk);
      chk(cle == 1'b1 && dq_oe == 1'b1 && !idle, "R9 accepted after idle", cle, 1);
      req_valid = 1'b0;
      k = 0;
      while (k < 20) begin
        @(negedge clk);
        k++;
        if (done) break;
      end
      @(negedge clk);
      chk(idle == 1'b1 && !done, "R10 back to idle", idle, 1);
    end
    finish_run();
  end
endmodule